// File: doc/BRIEF.md
# Loop-bound predicate mask generator

This unit turns one vector-loop iteration request into a byte-granular predicate mask. A request carries a scalar start index, a scalar limit, an element-size code and a comparison mode. For every element lane `i` the unit decides whether `start + i` still lies inside the bound. The mode selects a strict (`<`) or inclusive (`<=`) bound and a signed or unsigned reading of both operands. Each result is placed at the lowest byte of its element group inside a mask that holds one bit per byte of a `VL`-bit vector.

Along with the mask, the unit reports three condition flags: no lane active, the lowest lane active, and the highest lane active. Loop control uses these to stop the loop or to see that the iteration is the last one. Requests and results each move over a valid/ready handshake, and one request can pass per cycle. The result is held in an output register and stays there until the consumer takes it.

Top module: `loop_pred_gen`

## Requirements
- R1: While reset is high and in the first cycle after it, `rsp_valid` is 0 and `req_ready` is 1.
- R2: Element lane `i` is active when `start + i < limit` and `req_incl` = 0, or when `start + i <= limit` and `req_incl` = 1.
- R3: `req_esize` selects the element size: 00 byte, 01 half (2 bytes), 10 word (4 bytes), 11 double (8 bytes). The flag for element `j` appears at mask bit `j * bytes`. Every other mask bit is 0. There are `VL/8 / bytes` element lanes.
- R4: The active lanes form a contiguous run that starts at lane 0. Once one lane is inactive, every higher lane is inactive too.
- R5: With `req_signed` = 1, the start and limit are compared as two's-complement 64-bit values. With `req_signed` = 0, they are compared as unsigned values.
- R6: If `start + i` cannot be represented in 64 bits (signed or unsigned, as the mode selects), the sum does not wrap and lane `i` is inactive.
- R7: `rsp_none` is 1 exactly when no lane is active. `rsp_first` is 1 when lane 0 is active. `rsp_last` is 1 when the highest element lane for the selected size is active.
- R8: `req_ready` equals `!rsp_valid || rsp_ready`. A request accepted at a clock edge shows its result, with `rsp_valid` = 1, immediately after that edge.
- R9: While `rsp_valid` is 1 and `rsp_ready` is 0, the response stays valid and its mask and flags do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_start | input | 64 | Loop start index |
| req_limit | input | 64 | Loop bound |
| req_esize | input | 2 | Element-size code |
| req_signed | input | 1 | 1 = signed comparison |
| req_incl | input | 1 | 1 = inclusive (`<=`) bound |
| rsp_valid | output | 1 | Result present |
| rsp_ready | input | 1 | Consumer takes the result |
| rsp_pred | output | VL/8 | Byte-granular predicate mask |
| rsp_none | output | 1 | No lane active |
| rsp_first | output | 1 | Lowest lane active |
| rsp_last | output | 1 | Highest lane active |

## Verification
Any fault in the lane comparators, the overflow detection or the size placement shows up in the mask of the very response that carries it. The reference model predicts every mask and flag bit independently of the design. A stale or corrupted output register shows up in the first stalled cycle as a mask or flags that change while the response is still unconsumed. A lost or duplicated response shows up when the expected-result queue runs dry or finds itself out of order. Stimulus concentrates on the signed and unsigned overflow edges, a zero-length bound, all four element sizes, and back-pressure from the consumer.

// File: rtl/pmask_pkg.sv
package pmask_pkg;

    typedef enum logic [1:0] {
        ESZ_BYTE   = 2'b00,
        ESZ_HALF   = 2'b01,
        ESZ_WORD   = 2'b10,
        ESZ_DOUBLE = 2'b11
    } esize_e;

    typedef struct packed {
        logic is_signed;
        logic inclusive;
    } cmp_mode_t;

    typedef struct packed {
        logic none;
        logic first;
        logic last;
    } pflags_t;

    localparam int unsigned NUM_SIZES = 4;

    function automatic int unsigned elem_bytes(esize_e sz);
        return 32'd1 << sz;
    endfunction

endpackage

// File: rtl/pmask_lane_cmp.sv
module pmask_lane_cmp
    import pmask_pkg::*;
#(
    parameter int unsigned IDX_W = 64,
    parameter int unsigned NB    = 32
) (
    input  logic [IDX_W-1:0] start,
    input  logic [IDX_W-1:0] limit,
    input  cmp_mode_t        mode,
    output logic [NB-1:0]    hit
);

    for (genvar i = 0; i < NB; i++) begin : g_lane
        localparam logic [IDX_W:0] OFFSET = (IDX_W+1)'(i);
        logic [IDX_W:0] ext;
        logic [IDX_W:0] sum;
        logic           ovf;
        logic           below;
        logic           equal;

        always_comb begin
            ext   = mode.is_signed ? {start[IDX_W-1], start} : {1'b0, start};
            sum   = ext + OFFSET;
            ovf   = mode.is_signed ? (sum[IDX_W] != sum[IDX_W-1]) : sum[IDX_W];
            below = mode.is_signed ? ($signed(sum[IDX_W-1:0]) < $signed(limit))
                                   : (sum[IDX_W-1:0] < limit);
            equal = (sum[IDX_W-1:0] == limit);
            hit[i] = !ovf && (below || (mode.inclusive && equal));
        end
    end

endmodule

// File: rtl/pmask_place.sv
module pmask_place
    import pmask_pkg::*;
#(
    parameter int unsigned NB = 32
) (
    input  logic [NB-1:0] hit,
    input  esize_e        esize,
    output logic [NB-1:0] pred
);

    logic [NB-1:0] run;
    logic [NUM_SIZES-1:0][NB-1:0] cand;

    assign run[0] = hit[0];
    for (genvar j = 1; j < NB; j++) begin : g_run
        assign run[j] = run[j-1] & hit[j];
    end

    for (genvar e = 0; e < NUM_SIZES; e++) begin : g_size
        localparam int unsigned EB = 1 << e;
        localparam int unsigned NE = NB / EB;
        logic [NB-1:0] m;
        always_comb begin
            m = '0;
            for (int j = 0; j < NE; j++) begin
                m[j*EB] = run[j];
            end
        end
        assign cand[e] = m;
    end

    assign pred = cand[esize];

endmodule

// File: rtl/pmask_flags.sv
module pmask_flags
    import pmask_pkg::*;
#(
    parameter int unsigned NB = 32
) (
    input  logic [NB-1:0] hit,
    input  esize_e        esize,
    output pflags_t       flags
);

    logic [NUM_SIZES-1:0] all_in;

    for (genvar e = 0; e < NUM_SIZES; e++) begin : g_size
        localparam int unsigned NE = NB >> e;
        assign all_in[e] = &hit[NE-1:0];
    end

    always_comb begin
        flags.first = hit[0];
        flags.none  = !hit[0];
        flags.last  = all_in[esize];
    end

endmodule

// File: rtl/loop_pred_gen.sv
module loop_pred_gen
    import pmask_pkg::*;
#(
    parameter int unsigned VL    = 256,
    parameter int unsigned IDX_W = 64
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic [IDX_W-1:0]    req_start,
    input  logic [IDX_W-1:0]    req_limit,
    input  logic [1:0]          req_esize,
    input  logic                req_signed,
    input  logic                req_incl,
    output logic                rsp_valid,
    input  logic                rsp_ready,
    output logic [VL/8-1:0]     rsp_pred,
    output logic                rsp_none,
    output logic                rsp_first,
    output logic                rsp_last
);

    localparam int unsigned NB = VL / 8;

    cmp_mode_t     mode;
    esize_e        esize_in;
    logic [NB-1:0] hit;
    logic [NB-1:0] pred_d;
    pflags_t       flags_d;

    logic          valid_q;
    logic [NB-1:0] pred_q;
    pflags_t       flags_q;
    esize_e        esize_q;
    logic          accept;

    assign mode.is_signed = req_signed;
    assign mode.inclusive = req_incl;
    assign esize_in       = esize_e'(req_esize);

    pmask_lane_cmp #(.IDX_W(IDX_W), .NB(NB)) u_cmp (
        .start (req_start),
        .limit (req_limit),
        .mode  (mode),
        .hit   (hit)
    );

    pmask_place #(.NB(NB)) u_place (
        .hit   (hit),
        .esize (esize_in),
        .pred  (pred_d)
    );

    pmask_flags #(.NB(NB)) u_flags (
        .hit   (hit),
        .esize (esize_in),
        .flags (flags_d)
    );

    assign req_ready = !valid_q || rsp_ready;
    assign accept    = req_valid && req_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            pred_q  <= '0;
            flags_q <= '0;
            esize_q <= ESZ_BYTE;
        end else begin
            if (accept) begin
                valid_q <= 1'b1;
                pred_q  <= pred_d;
                flags_q <= flags_d;
                esize_q <= esize_in;
            end else if (rsp_ready) begin
                valid_q <= 1'b0;
            end
        end
    end

    assign rsp_valid = valid_q;
    assign rsp_pred  = pred_q;
    assign rsp_none  = flags_q.none;
    assign rsp_first = flags_q.first;
    assign rsp_last  = flags_q.last;

    // ---------------- assertions ----------------
    logic [NB-1:0] grid_q;
    int unsigned   last_idx_q;

    always_comb begin
        for (int b = 0; b < NB; b++) begin
            grid_q[b] = ((b % elem_bytes(esize_q)) == 0);
        end
        last_idx_q = NB - elem_bytes(esize_q);
    end

    p_contig_r4: assert property (@(posedge clk) disable iff (rst)
        req_valid |-> ((hit & (hit + 1'b1)) == '0));

    p_pad_zero_r3: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> ((rsp_pred & ~grid_q) == '0));

    p_none_r7: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> (rsp_none == (rsp_pred == '0)));

    p_first_r7: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> (rsp_first == rsp_pred[0]));

    p_last_r7: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> (rsp_last == rsp_pred[last_idx_q]));

    p_result_next_r8: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> rsp_valid);

    p_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_pred)
                                       && $stable(rsp_none) && $stable(rsp_last)));

endmodule

// File: tb/loop_pred_gen_test.sv
`timescale 1ns/1ps
module loop_pred_gen_test;

    localparam int VL = 256;
    localparam int NB = VL / 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [63:0]   req_start = '0;
    logic [63:0]   req_limit = '0;
    logic [1:0]    req_esize = '0;
    logic          req_signed = 1'b0;
    logic          req_incl = 1'b0;
    logic          rsp_valid;
    logic          rsp_ready = 1'b1;
    logic [NB-1:0] rsp_pred;
    logic          rsp_none, rsp_first, rsp_last;

    always #2.5 clk = ~clk;

    loop_pred_gen #(.VL(VL), .IDX_W(64)) uut (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_start(req_start), .req_limit(req_limit),
        .req_esize(req_esize), .req_signed(req_signed), .req_incl(req_incl),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
        .rsp_pred(rsp_pred), .rsp_none(rsp_none),
        .rsp_first(rsp_first), .rsp_last(rsp_last)
    );

    typedef struct {
        logic [NB-1:0] pred;
        logic          none;
        logic          first;
        logic          last;
        string         tag;
    } exp_t;

    exp_t          expq[$];
    int            n_checks = 0;
    int            n_fail = 0;
    bit            finished = 0;
    int            bp_mode = 0;
    bit            accepted_last = 0;
    bit            stalled = 0;
    logic [NB-1:0] held_pred;
    logic [2:0]    held_flags;

    task automatic check(input bit ok, input string tag, input logic [63:0] act,
                         input logic [63:0] expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    function automatic exp_t model(logic [63:0] st, logic [63:0] lim, logic [1:0] es,
                                   logic sg, logic inc, string tag);
        exp_t r;
        int   eb = 1 << es;
        int   n = NB / eb;
        bit   alive = 1;
        r.pred = '0;
        r.tag  = tag;
        for (int j = 0; j < n; j++) begin
            bit ok;
            if (sg) begin
                longint s = longint'(st);
                longint l = longint'(lim);
                if (s > 64'sh7FFF_FFFF_FFFF_FFFF - longint'(j)) ok = 0;
                else ok = inc ? (s + longint'(j) <= l) : (s + longint'(j) < l);
            end else begin
                if (st > ~64'd0 - 64'(j)) ok = 0;
                else ok = inc ? (st + 64'(j) <= lim) : (st + 64'(j) < lim);
            end
            alive = alive && ok;
            if (alive) r.pred[j*eb] = 1'b1;
        end
        r.none  = (r.pred == '0);
        r.first = r.pred[0];
        r.last  = r.pred[(n-1)*eb];
        return r;
    endfunction

    function automatic logic pick_ready();
        case (bp_mode)
            0: return 1'b1;
            1: return 1'b0;
            default: return 1'($urandom_range(0, 1));
        endcase
    endfunction

    // Evaluated 1 ns after each falling edge; decisions apply at the next rising edge.
    task automatic observe();
        check(req_ready == (!rsp_valid || rsp_ready), "R8 ready rule",
              64'(req_ready), 64'(!rsp_valid || rsp_ready));
        if (accepted_last)
            check(rsp_valid == 1'b1, "R8 result one cycle after accept", 64'(rsp_valid), 64'd1);
        if (stalled) begin
            check(rsp_valid && rsp_pred == held_pred
                  && {rsp_none, rsp_first, rsp_last} == held_flags,
                  "R9 hold while stalled", 64'(rsp_pred), 64'(held_pred));
        end
        stalled = rsp_valid && !rsp_ready;
        held_pred  = rsp_pred;
        held_flags = {rsp_none, rsp_first, rsp_last};
        if (rsp_valid && rsp_ready) begin
            if (expq.size() == 0) begin
                check(0, "R8 unexpected response", 64'(rsp_pred), 64'd0);
            end else begin
                exp_t e = expq.pop_front();
                check(rsp_pred == e.pred, e.tag, 64'(rsp_pred), 64'(e.pred));
                check({rsp_none, rsp_first, rsp_last} == {e.none, e.first, e.last},
                      "R7 flags none/first/last",
                      64'({rsp_none, rsp_first, rsp_last}), 64'({e.none, e.first, e.last}));
            end
        end
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            req_valid = 1'b0;
            rsp_ready = pick_ready();
            #1;
            observe();
            accepted_last = 0;
        end
    endtask

    task automatic send(input logic [63:0] st, input logic [63:0] lim, input logic [1:0] es,
                        input logic sg, input logic inc, input string tag);
        bit done = 0;
        while (!done) begin
            @(negedge clk);
            req_valid  = 1'b1;
            req_start  = st;
            req_limit  = lim;
            req_esize  = es;
            req_signed = sg;
            req_incl   = inc;
            rsp_ready  = pick_ready();
            #1;
            observe();
            accepted_last = 0;
            if (req_ready) begin
                expq.push_back(model(st, lim, es, sg, inc, tag));
                accepted_last = 1;
                done = 1;
            end
        end
    endtask

    function automatic logic [63:0] edge_val();
        case ($urandom_range(0, 7))
            0: return 64'd0;
            1: return 64'($urandom_range(0, 80));
            2: return ~64'd0 - 64'($urandom_range(0, 40));
            3: return 64'h7FFF_FFFF_FFFF_FFFF - 64'($urandom_range(0, 40));
            4: return 64'h8000_0000_0000_0000 + 64'($urandom_range(0, 40));
            5: return 64'(-$urandom_range(0, 40));
            default: return {$urandom, $urandom};
        endcase
    endfunction

    initial begin
        #(5.0 * 150000);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: R8 run did not complete actual=hung expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        check(rsp_valid == 1'b0 && req_ready == 1'b1, "R1 state in reset",
              64'({rsp_valid, req_ready}), 64'b01);
        @(negedge clk);
        rst = 1'b0;
        #1;
        check(rsp_valid == 1'b0 && req_ready == 1'b1, "R1 state after reset",
              64'({rsp_valid, req_ready}), 64'b01);

        // word lanes, 100-element tail: 4 of 8 lanes
        send(64'd96, 64'd100, 2'b10, 1'b0, 1'b0, "R2 tail of word loop");
        send(64'd0, 64'd0, 2'b00, 1'b0, 1'b0, "R2 strict empty bound");
        send(64'd0, 64'd0, 2'b00, 1'b0, 1'b1, "R2 inclusive single lane");
        send(64'd10, 64'd100, 2'b00, 1'b0, 1'b0, "R3 byte all lanes");
        send(64'd5, 64'd9, 2'b01, 1'b0, 1'b1, "R3 half placement");
        send(64'd0, 64'd3, 2'b11, 1'b0, 1'b0, "R3 double placement");
        send(64'd0, 64'd4, 2'b11, 1'b0, 1'b0, "R3 double all lanes");
        send(64'd3, 64'd20, 2'b00, 1'b0, 1'b0, "R4 contiguous byte run");
        send(64'(-5), 64'd2, 2'b00, 1'b1, 1'b0, "R5 signed negative start");
        send(64'(-5), 64'd2, 2'b00, 1'b0, 1'b0, "R5 same bits unsigned");
        send(64'd1, 64'(-1), 2'b10, 1'b1, 1'b0, "R5 signed negative limit");
        send(~64'd0 - 64'd2, ~64'd0, 2'b00, 1'b0, 1'b1, "R6 unsigned overflow");
        send(64'h7FFF_FFFF_FFFF_FFFE, 64'h7FFF_FFFF_FFFF_FFFF, 2'b00, 1'b1, 1'b1,
             "R6 signed overflow");
        idle(3);

        // back-pressure
        bp_mode = 1;
        send(64'd2, 64'd7, 2'b01, 1'b0, 1'b0, "R9 stalled response");
        idle(4);
        bp_mode = 0;
        idle(2);

        bp_mode = 2;
        for (int t = 0; t < 600; t++) begin
            send(edge_val(), edge_val(), 2'($urandom_range(0, 3)),
                 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), "R2 mixed request");
            if ($urandom_range(0, 3) == 0) idle(1);
        end
        bp_mode = 0;
        idle(4);
        check(expq.size() == 0, "R8 all responses delivered", 64'(expq.size()), 64'd0);

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule